// File: doc/BRIEF.md
# Serial Flash Byte Access Sequencer

This block turns byte-level requests (read one byte, write one byte, erase the sector) into the pin-level sequences that an on-chip flash array with serially loaded address and data registers expects. It presents 256 byte locations. Each byte is the upper half of one 16-bit word in sector 0, so the array looks like a small 2-Kbit byte-wide EEPROM. The lower half of every word is never altered by a write.

A request is taken in the cycle that `req_valid` is high and the sequencer is idle. The sequencer then holds `busy` high. It shifts the 9-bit word address into the array and then either reads the word back serially, or loads the program data and strobes program. An erase loads the address and strobes erase. For program and erase it waits until the array reports busy and then idle. `done` pulses for one cycle at completion, and for reads `rdata` holds the returned byte. While `reprog_busy` is high, new write and erase requests are not accepted. Reads are still accepted, and an operation already in progress runs to its end.

Top module: `flash_byte_seq`

## Requirements
- R1: After reset, `busy`, `done`, both strobes, both array clocks, both shift enables and `arr_osc_en` are low.
- R2: Every accepted request loads the array address with exactly 9 address clock pulses, MSB first, with `arr_addr_shift` high, and the value is {1'b0, req_addr}.
- R3: A read (`req_op` = 2'b00) returns bits [15:8] of the addressed word on `rdata` when `done` pulses. Example: after 0xAC is written to address 0xD3, a read of 0xD3 returns 0xAC.
- R4: A write (`req_op` = 2'b01) loads the 16-bit data register MSB first with {req_wdata, 8'hFF} and then pulses `arr_prog`, so the upper byte takes the new value and bits [7:0] of the word are unchanged.
- R5: An erase (`req_op` = 2'b10) pulses `arr_erase`, after which every location reads 0xFF.
- R6: While `reprog_busy` is high, write and erase requests are ignored: `busy` stays low, no strobe is issued and the stored data is unchanged. Reads are still served.
- R7: If `reprog_busy` rises while an operation is in progress, that operation completes normally.
- R8: `busy` stays high from the cycle after acceptance until `done` pulses. `done` is one cycle wide. A request presented while busy is ignored.
- R9: After a program or erase strobe, `done` is raised only after `arr_busy` has risen and then fallen.
- R10: The array clocks run at half the system clock rate: each is high for one cycle at a time, and the serial data input is stable while its clock is high.
- R11: The program and erase strobes are never high together, and each is one cycle wide.
- R12: A request with `req_op` = 2'b11 is ignored and `busy` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 2 | 00 read, 01 write, 10 erase, 11 ignored |
| req_addr | input | 8 | Byte location |
| req_wdata | input | 8 | Write data |
| reprog_busy | input | 1 | Reprogramming pending; blocks new write and erase |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Byte returned by the last read |
| arr_addr_shift | output | 1 | Address register shift enable |
| arr_addr_clk | output | 1 | Address register clock |
| arr_addr_din | output | 1 | Address register serial input |
| arr_data_shift | output | 1 | Data register shift enable (low = parallel capture) |
| arr_data_clk | output | 1 | Data register clock |
| arr_data_din | output | 1 | Data register serial input |
| arr_dout | input | 1 | Data register serial output |
| arr_prog | output | 1 | Program strobe |
| arr_erase | output | 1 | Erase strobe |
| arr_osc_en | output | 1 | Array oscillator enable |
| arr_busy | input | 1 | Array program/erase in progress |

## Verification
A bit counter that is off by one, or a shift register that slips, loads the wrong word address. This shows up in the address clock count and in the latched address on the first request after the fault, and in read-back data one operation later. A wrong program pattern shows up as a changed lower byte in the array as soon as the write finishes. A wait state that skips the array busy handshake raises `done` before the array has finished, and this is visible on that same operation. Faulty gating on the reprogramming flag shows up within a few cycles as `busy` rising, or as a missing request.

// File: rtl/flash_byte_seq.sv
module flash_byte_seq #(
  parameter int BYTE_W = 8,
  parameter int WORD_W = 16,
  parameter int FADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [BYTE_W-1:0] req_addr,
  input  logic [BYTE_W-1:0] req_wdata,
  input  logic              reprog_busy,
  output logic              busy,
  output logic              done,
  output logic [BYTE_W-1:0] rdata,
  output logic              arr_addr_shift,
  output logic              arr_addr_clk,
  output logic              arr_addr_din,
  output logic              arr_data_shift,
  output logic              arr_data_clk,
  output logic              arr_data_din,
  input  logic              arr_dout,
  output logic              arr_prog,
  output logic              arr_erase,
  output logic              arr_osc_en,
  input  logic              arr_busy
);
  localparam int CNT_W = $clog2(WORD_W) + 1;
  localparam logic [1:0] OP_RD = 2'b00, OP_WR = 2'b01, OP_ER = 2'b10;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_RCAP, S_RSH, S_WLD, S_STB, S_WHI, S_WLO} st_t;

  st_t              st;
  logic             ph;
  logic [CNT_W-1:0] cnt;
  logic [WORD_W-1:0] sr;
  logic [1:0]       op_q;
  logic             aclk_q, dclk_q;

  wire op_ok  = (req_op == OP_RD) || ((req_op == OP_WR || req_op == OP_ER) && !reprog_busy);
  wire accept = (st == S_IDLE) && req_valid && op_ok;
  wire dser   = (st == S_RCAP) || (st == S_RSH) || (st == S_WLD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= 1'b0; cnt <= '0; sr <= '0; op_q <= OP_RD;
      rdata <= '0; done <= 1'b0; aclk_q <= 1'b0; dclk_q <= 1'b0;
    end else begin
      done   <= 1'b0;
      aclk_q <= (st == S_ADDR) && !ph;
      dclk_q <= dser && !ph;
      case (st)
        S_IDLE: begin
          ph <= 1'b0; cnt <= '0;
          if (accept) begin
            op_q <= req_op;
            sr   <= {{(WORD_W-FADDR_W+1){1'b0}}, req_addr} << (WORD_W - FADDR_W);
            st   <= S_ADDR;
          end
        end
        S_ADDR: begin
          ph <= ~ph;
          if (ph) begin
            sr  <= sr << 1;
            cnt <= cnt + 1'b1;
            if (cnt == CNT_W'(FADDR_W - 1)) begin
              cnt <= '0;
              case (op_q)
                OP_RD:   st <= S_RCAP;
                OP_WR:   begin sr <= {req_wdata_q, {(WORD_W-BYTE_W){1'b1}}}; st <= S_WLD; end
                default: st <= S_STB;
              endcase
            end
          end
        end
        S_RCAP: begin
          ph <= ~ph;
          if (ph) st <= S_RSH;
        end
        S_RSH: begin
          ph <= ~ph;
          if (!ph && cnt < CNT_W'(BYTE_W)) rdata <= {rdata[BYTE_W-2:0], arr_dout};
          if (ph) begin
            cnt <= cnt + 1'b1;
            if (cnt == CNT_W'(WORD_W - 1)) begin st <= S_IDLE; done <= 1'b1; end
          end
        end
        S_WLD: begin
          ph <= ~ph;
          if (ph) begin
            sr  <= sr << 1;
            cnt <= cnt + 1'b1;
            if (cnt == CNT_W'(WORD_W - 1)) st <= S_STB;
          end
        end
        S_STB: st <= S_WHI;
        S_WHI: if (arr_busy) st <= S_WLO;
        S_WLO: if (!arr_busy) begin st <= S_IDLE; done <= 1'b1; end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [BYTE_W-1:0] req_wdata_q;
  always_ff @(posedge clk) begin
    if (!rst_n) req_wdata_q <= '0;
    else if (accept) req_wdata_q <= req_wdata;
  end

  assign busy           = (st != S_IDLE);
  assign arr_osc_en     = busy;
  assign arr_addr_shift = (st == S_ADDR);
  assign arr_addr_clk   = aclk_q;
  assign arr_addr_din   = (st == S_ADDR) && sr[WORD_W-1];
  assign arr_data_shift = (st == S_RSH) || (st == S_WLD);
  assign arr_data_clk   = dclk_q;
  assign arr_data_din   = (st == S_WLD) ? sr[WORD_W-1] : 1'b1;
  assign arr_prog       = (st == S_STB) && (op_q == OP_WR);
  assign arr_erase      = (st == S_STB) && (op_q == OP_ER);

  AST_ACLK_HALF_RATE: assert property (@(posedge clk) disable iff (!rst_n) arr_addr_clk |=> !arr_addr_clk); // R10
  AST_DCLK_HALF_RATE: assert property (@(posedge clk) disable iff (!rst_n) arr_data_clk |=> !arr_data_clk); // R10
  AST_ADIN_STABLE: assert property (@(posedge clk) disable iff (!rst_n) arr_addr_clk |-> $stable(arr_addr_din)); // R10
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(arr_prog && arr_erase)); // R11
  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) (arr_prog || arr_erase) |=> !(arr_prog || arr_erase)); // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R8
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy && $past(busy)); // R8
  AST_GATED_START: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) && $past(reprog_busy) |-> op_q == OP_RD); // R6
  AST_DONE_AFTER_ARRAY: assert property (@(posedge clk) disable iff (!rst_n) done && op_q != OP_RD |-> $past(!arr_busy)); // R9
endmodule

// File: tb/flash_byte_seq_tb.sv
`timescale 1ns/1ps
module flash_byte_seq_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, reprog_busy = 1'b0;
  logic [1:0] req_op = 2'b00;
  logic [7:0] req_addr = '0, req_wdata = '0;
  logic busy, done, arr_addr_shift, arr_addr_clk, arr_addr_din;
  logic arr_data_shift, arr_data_clk, arr_data_din, arr_prog, arr_erase, arr_osc_en;
  logic [7:0] rdata;
  logic arr_dout, arr_busy;
  int n_chk = 0, n_fail = 0, cyc = 0;

  always #2.5 clk = ~clk;

  flash_byte_seq dut_i (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .reprog_busy(reprog_busy), .busy(busy),
    .done(done), .rdata(rdata), .arr_addr_shift(arr_addr_shift), .arr_addr_clk(arr_addr_clk),
    .arr_addr_din(arr_addr_din), .arr_data_shift(arr_data_shift), .arr_data_clk(arr_data_clk),
    .arr_data_din(arr_data_din), .arr_dout(arr_dout), .arr_prog(arr_prog), .arr_erase(arr_erase),
    .arr_osc_en(arr_osc_en), .arr_busy(arr_busy));

  // flash array model
  logic [15:0] mem [512];
  logic [8:0]  areg = '0;
  logic [15:0] dreg = '0;
  int aclk_cnt = 0, strobe_cnt = 0, mtmr = 0;
  logic mpend = 1'b0, mkind = 1'b0, mbusy = 1'b0, mbusy_fell = 1'b0;
  assign arr_dout = dreg[15];
  assign arr_busy = mbusy;

  function automatic logic [7:0] lo_init(int i);
    return 8'(i) ^ 8'h3C;
  endfunction

  initial for (int i = 0; i < 512; i++) mem[i] = {8'hFF, lo_init(i)};

  always @(posedge arr_addr_clk) if (arr_addr_shift) begin
    areg <= {areg[7:0], arr_addr_din};
    aclk_cnt <= aclk_cnt + 1;
  end
  always @(posedge arr_data_clk) begin
    if (arr_data_shift) dreg <= {dreg[14:0], arr_data_din};
    else dreg <= mem[areg];
  end
  always @(posedge clk) begin
    if (arr_prog || arr_erase) begin
      mpend <= 1'b1; mkind <= arr_erase; mtmr <= 0; strobe_cnt <= strobe_cnt + 1;
    end else if (mpend) begin
      mtmr <= mtmr + 1;
      if (mtmr == 2) mbusy <= 1'b1;
      if (mtmr == 12) begin
        if (mkind) for (int i = 0; i < 256; i++) mem[i] = 16'hFFFF;
        else mem[areg] = mem[areg] & dreg;
        mbusy <= 1'b0; mpend <= 1'b0; mbusy_fell <= 1'b1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected done", cyc);
      finish_run();
    end
  end

  // run one op to completion; returns rdata
  task automatic do_op(input logic [1:0] op, input logic [7:0] a, input logic [7:0] d,
                       output logic [7:0] rd);
    int waited = 0;
    bit busy_ok = 1'b1;
    @(negedge clk);
    aclk_cnt = 0; mbusy_fell = 1'b0;
    req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done && waited < 2000) begin
      if (!busy) busy_ok = 1'b0;
      @(negedge clk); waited++;
    end
    chk(busy_ok && done, "R8 busy held until done", busy_ok, 1);
    chk(aclk_cnt == 9 && areg == {1'b0, a}, "R2 address load", {aclk_cnt, areg}, {9, 1'b0, a});
    if (op != 2'b00) chk(mbusy_fell, "R9 done after array busy", mbusy_fell, 1);
    rd = rdata;
    @(negedge clk);
    chk(!done, "R8 done one cycle", done, 0);
  endtask

  // {op, addr, data, expected}
  localparam logic [25:0] VEC [9] = '{
    {2'b01, 8'hD3, 8'hAC, 8'h00},
    {2'b00, 8'hD3, 8'h00, 8'hAC},
    {2'b01, 8'h00, 8'h3C, 8'h00},
    {2'b00, 8'h00, 8'h00, 8'h3C},
    {2'b00, 8'h01, 8'h00, 8'hFF},
    {2'b01, 8'hFF, 8'h81, 8'h00},
    {2'b00, 8'hFF, 8'h00, 8'h81},
    {2'b10, 8'h00, 8'h00, 8'h00},
    {2'b00, 8'hD3, 8'h00, 8'hFF}
  };

  task automatic idle_watch(input int n, input string req);
    bit stayed = 1'b1;
    int s0 = strobe_cnt;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (busy) stayed = 1'b0;
    end
    chk(stayed && strobe_cnt == s0, req, {stayed, 4'(strobe_cnt - s0)}, 16);
  endtask

  initial begin
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !arr_prog && !arr_erase && !arr_addr_clk && !arr_data_clk &&
        !arr_addr_shift && !arr_data_shift && !arr_osc_en, "R1 reset state", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !arr_osc_en, "R1 idle after reset", busy, 0);

    foreach (VEC[i]) begin
      do_op(VEC[i][25:24], VEC[i][23:16], VEC[i][15:8], rd);
      if (VEC[i][25:24] == 2'b00)
        chk(rd == VEC[i][7:0], (VEC[i][7:0] == 8'hFF && i == 8) ? "R5 erased reads FF" : "R3 read data", rd, VEC[i][7:0]);
      if (VEC[i][25:24] == 2'b01)
        chk(mem[VEC[i][23:16]] == {VEC[i][15:8], lo_init(VEC[i][23:16])}, "R4 upper written, lower kept",
            mem[VEC[i][23:16]], {VEC[i][15:8], lo_init(VEC[i][23:16])});
      if (VEC[i][25:24] == 2'b10)
        chk(mem[0] == 16'hFFFF && mem[255] == 16'hFFFF, "R5 sector erased", mem[255], 16'hFFFF);
    end

    // R6: gated write and erase
    reprog_busy = 1'b1;
    @(negedge clk); req_valid = 1'b1; req_op = 2'b01; req_addr = 8'h40; req_wdata = 8'h00;
    @(negedge clk); req_valid = 1'b0;
    idle_watch(40, "R6 write ignored while reprog busy");
    @(negedge clk); req_valid = 1'b1; req_op = 2'b10;
    @(negedge clk); req_valid = 1'b0;
    idle_watch(40, "R6 erase ignored while reprog busy");
    do_op(2'b00, 8'h40, 8'h00, rd);
    chk(rd == 8'hFF, "R6 read served, data unchanged", rd, 8'hFF);
    reprog_busy = 1'b0;

    // R7: reprog rises mid write
    fork
      do_op(2'b01, 8'h20, 8'h11, rd);
      begin repeat (10) @(negedge clk); reprog_busy = 1'b1; end
    join
    reprog_busy = 1'b0;
    do_op(2'b00, 8'h20, 8'h00, rd);
    chk(rd == 8'h11, "R7 in-flight write completed", rd, 8'h11);

    // R8: request while busy ignored
    fork
      do_op(2'b01, 8'h30, 8'h22, rd);
      begin
        repeat (5) @(negedge clk);
        req_valid = 1'b1; req_op = 2'b01; req_addr = 8'h31; req_wdata = 8'h00;
        @(negedge clk); req_valid = 1'b0; req_addr = 8'h30; req_wdata = 8'h22;
      end
    join
    do_op(2'b00, 8'h31, 8'h00, rd);
    chk(rd == 8'hFF, "R8 request while busy ignored", rd, 8'hFF);

    // R12: reserved op
    @(negedge clk); req_valid = 1'b1; req_op = 2'b11; req_addr = 8'h50;
    @(negedge clk); req_valid = 1'b0;
    idle_watch(30, "R12 reserved op ignored");

    finish_run();
  end
endmodule